// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a small multi-cycle processor built around separate memories: one for 16-bit instructions, one for 8-bit data. On each clock edge it moves through a short path of states for the instruction at hand. Every path starts with an instruction fetch and a decode step. The decode step picks the execute path from the 4-bit opcode, taken from bits 15:12 of the instruction register. For conditional branches it also picks the path from the zero or carry flag. The block drives only the datapath controls. The register file, ALU, program counter and memories sit outside it.

All outputs are Moore outputs: they depend only on the state register and a small ALU-operation register that is captured at decode. Every state gives every output a value, and outputs that a state does not use take a fixed default, so all the output logic is combinational. Reset is synchronous and active-high.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is Fetch, and the ALU-operation register returns to add (010). An encoding that names no state also leads to Fetch.
- R2: Fetch drives `mem_rd`=1, `ir_wr`=1, `alu_op`=010, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (fetch step constant), `pc_wr`=1, `pc_src`=00 (ALU), and every other output 0. Fetch is always followed by Decode. Decode drives `alu_op`=010, `alu_a_sel`=0, `alu_b_sel`=10 (address field), which precomputes the branch target, and every other output 0.
- R3: ALU opcodes 0 to 6 (add, add-with-carry, subtract, subtract-with-borrow, and, or, xor) take Fetch, Decode, Execute and Writeback, one cycle each, and then return to Fetch. Execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `flag_upd`=1. Writeback drives `reg_wr`=1, `wb_sel`=00 (ALU) and `reg_dst`=0 (field 8:6).
- R4: In Execute, `alu_op` takes the code for the opcode captured at Decode: and=000, or=001, add=010, xor=011, add-with-carry=100, subtract-with-borrow=101, subtract=110. A change of `opcode` after Decode does not alter it.
- R5: Opcode 7 (immediate load) goes from Decode to one cycle with `reg_wr`=1, `wb_sel`=10 (immediate) and `reg_dst`=1 (field 11:9), then to Fetch.
- R6: Opcode 8 (direct load) goes through one cycle with `mem_rd`=1 and `daddr_sel`=0 (address field). It then has a writeback cycle with `reg_wr`=1, `wb_sel`=01 (memory data) and `reg_dst`=1, then returns to Fetch.
- R7: Opcode 9 (register-indirect load) goes through one cycle with `mem_rd`=1 and `daddr_sel`=1 (register). It then has a writeback cycle with `reg_wr`=1, `wb_sel`=01 and `reg_dst`=0, then returns to Fetch.
- R8: Opcode 10 (store) goes through one cycle with `mem_wr`=1 and `daddr_sel`=0, then returns to Fetch with no register write.
- R9: Opcode 11 tests `zero_flag` and opcode 12 tests `carry_flag`. Each flag is sampled only at the edge that leaves Decode. If the flag is set, one cycle follows with `pc_wr_cond`=1, `pc_src`=01 (branch target) and `pc_wr`=0, then Fetch. If the flag is clear, Decode goes straight back to Fetch.
- R10: Opcode 13 (direct jump) has one cycle with `pc_wr`=1 and `pc_src`=10 (address field). Opcode 14 (register jump) has one cycle with `pc_wr`=1 and `pc_src`=11 (register). Both then return to Fetch.
- R11: Opcode 15 returns from Decode to Fetch with no write strobe.
- R12: `flag_upd` is asserted only in an ALU Execute cycle. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| zero_flag | input | 1 | Stored ALU zero flag |
| carry_flag | input | 1 | Stored ALU carry/borrow flag |
| mem_rd | output | 1 | Memory read strobe (instruction in Fetch, data in loads) |
| mem_wr | output | 1 | Data memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination field: 0 = bits 8:6, 1 = bits 11:9 |
| wb_sel | output | 2 | Write-back source: 00 ALU, 01 memory, 10 immediate |
| alu_op | output | 3 | ALU operation code |
| alu_a_sel | output | 1 | ALU A: 0 = PC, 1 = register |
| alu_b_sel | output | 2 | ALU B: 00 register, 01 step constant, 10 address field |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | Taken-branch PC write |
| pc_src | output | 2 | PC source: 00 ALU, 01 target, 10 address, 11 register |
| daddr_sel | output | 1 | Data address: 0 = address field, 1 = register |
| flag_upd | output | 1 | Zero/carry flag update enable |

## Verification
In Decode, two things happen in the same cycle: the ALU is set up to add the branch offset, and the branch flag is sampled to choose the next state. The bench presents the flags only during the Decode cycle. It tries each branch opcode with its own flag set, with only the other flag set, and with neither. It then flips the flags during the branch cycle and checks that nothing further changes. ALU ops are probed the same way: the opcode input changes right after Decode, and the Execute-cycle `alu_op` must still match the captured instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [3:0] {
        S_FETCH   = 4'd0,
        S_DECODE  = 4'd1,
        S_EX_ALU  = 4'd2,
        S_WB_ALU  = 4'd3,
        S_WB_IMM  = 4'd4,
        S_MEM_LDD = 4'd5,
        S_WB_LDD  = 4'd6,
        S_MEM_LDR = 4'd7,
        S_WB_LDR  = 4'd8,
        S_MEM_ST  = 4'd9,
        S_EX_BR   = 4'd10,
        S_EX_JMP  = 4'd11,
        S_EX_JR   = 4'd12
    } state_e;

    localparam logic [OPC_W-1:0] OP_ADD = 4'd0;
    localparam logic [OPC_W-1:0] OP_ADC = 4'd1;
    localparam logic [OPC_W-1:0] OP_SUB = 4'd2;
    localparam logic [OPC_W-1:0] OP_SBB = 4'd3;
    localparam logic [OPC_W-1:0] OP_AND = 4'd4;
    localparam logic [OPC_W-1:0] OP_OR  = 4'd5;
    localparam logic [OPC_W-1:0] OP_XOR = 4'd6;
    localparam logic [OPC_W-1:0] OP_LDI = 4'd7;
    localparam logic [OPC_W-1:0] OP_LDD = 4'd8;
    localparam logic [OPC_W-1:0] OP_LDR = 4'd9;
    localparam logic [OPC_W-1:0] OP_STB = 4'd10;
    localparam logic [OPC_W-1:0] OP_BZ  = 4'd11;
    localparam logic [OPC_W-1:0] OP_BC  = 4'd12;
    localparam logic [OPC_W-1:0] OP_JMP = 4'd13;
    localparam logic [OPC_W-1:0] OP_JR  = 4'd14;

    localparam logic [ALUOP_W-1:0] AL_AND = 3'b000;
    localparam logic [ALUOP_W-1:0] AL_OR  = 3'b001;
    localparam logic [ALUOP_W-1:0] AL_ADD = 3'b010;
    localparam logic [ALUOP_W-1:0] AL_XOR = 3'b011;
    localparam logic [ALUOP_W-1:0] AL_ADC = 3'b100;
    localparam logic [ALUOP_W-1:0] AL_SBB = 3'b101;
    localparam logic [ALUOP_W-1:0] AL_SUB = 3'b110;

    localparam logic [SEL_W-1:0] BS_REG  = 2'b00;
    localparam logic [SEL_W-1:0] BS_STEP = 2'b01;
    localparam logic [SEL_W-1:0] BS_ADDR = 2'b10;

    localparam logic [SEL_W-1:0] PS_ALU    = 2'b00;
    localparam logic [SEL_W-1:0] PS_TARGET = 2'b01;
    localparam logic [SEL_W-1:0] PS_ADDR   = 2'b10;
    localparam logic [SEL_W-1:0] PS_REG    = 2'b11;

    localparam logic [SEL_W-1:0] WB_ALU = 2'b00;
    localparam logic [SEL_W-1:0] WB_MEM = 2'b01;
    localparam logic [SEL_W-1:0] WB_IMM = 2'b10;

    typedef struct packed {
        logic               mem_rd;
        logic               mem_wr;
        logic               ir_wr;
        logic               reg_wr;
        logic               reg_dst;
        logic [SEL_W-1:0]   wb_sel;
        logic [ALUOP_W-1:0] alu_op;
        logic               alu_a_sel;
        logic [SEL_W-1:0]   alu_b_sel;
        logic               pc_wr;
        logic               pc_wr_cond;
        logic [SEL_W-1:0]   pc_src;
        logic               daddr_sel;
        logic               flag_upd;
    } ctl_t;

    function automatic ctl_t ctl_idle();
        ctl_t c;
        c = '0;
        c.alu_op = AL_ADD;
        return c;
    endfunction

    function automatic logic [ALUOP_W-1:0] alu_code(input logic [OPC_W-1:0] opc);
        case (opc)
            OP_ADC:  return AL_ADC;
            OP_SUB:  return AL_SUB;
            OP_SBB:  return AL_SBB;
            OP_AND:  return AL_AND;
            OP_OR:   return AL_OR;
            OP_XOR:  return AL_XOR;
            default: return AL_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic               zero_flag,
    input  logic               carry_flag,
    output state_e             exec_state,
    output logic [ALUOP_W-1:0] exec_alu
);

    always_comb begin
        exec_alu = alu_code(opcode);
        case (opcode)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB,
            OP_AND, OP_OR, OP_XOR: exec_state = S_EX_ALU;
            OP_LDI:                exec_state = S_WB_IMM;
            OP_LDD:                exec_state = S_MEM_LDD;
            OP_LDR:                exec_state = S_MEM_LDR;
            OP_STB:                exec_state = S_MEM_ST;
            OP_BZ:                 exec_state = zero_flag  ? S_EX_BR : S_FETCH;
            OP_BC:                 exec_state = carry_flag ? S_EX_BR : S_FETCH;
            OP_JMP:                exec_state = S_EX_JMP;
            OP_JR:                 exec_state = S_EX_JR;
            default:               exec_state = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_outputs.sv
module mc_ctrl_outputs
    import mc_ctrl_pkg::*;
(
    input  state_e             state,
    input  logic [ALUOP_W-1:0] alu_q,
    output ctl_t               ctl
);

    always_comb begin
        ctl = ctl_idle();
        case (state)
            S_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_b_sel = BS_STEP;
                ctl.pc_wr     = 1'b1;
                ctl.pc_src    = PS_ALU;
            end
            S_DECODE: ctl.alu_b_sel = BS_ADDR;
            S_EX_ALU: begin
                ctl.alu_op    = alu_q;
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BS_REG;
                ctl.flag_upd  = 1'b1;
            end
            S_WB_ALU: begin
                ctl.reg_wr = 1'b1;
                ctl.wb_sel = WB_ALU;
            end
            S_WB_IMM: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
                ctl.wb_sel  = WB_IMM;
            end
            S_MEM_LDD: ctl.mem_rd = 1'b1;
            S_WB_LDD: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
                ctl.wb_sel  = WB_MEM;
            end
            S_MEM_LDR: begin
                ctl.mem_rd    = 1'b1;
                ctl.daddr_sel = 1'b1;
            end
            S_WB_LDR: begin
                ctl.reg_wr = 1'b1;
                ctl.wb_sel = WB_MEM;
            end
            S_MEM_ST: ctl.mem_wr = 1'b1;
            S_EX_BR: begin
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PS_TARGET;
            end
            S_EX_JMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PS_ADDR;
            end
            S_EX_JR: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PS_REG;
            end
            default: ctl = ctl_idle();
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   opcode,
    input  logic         zero_flag,
    input  logic         carry_flag,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         ir_wr,
    output logic         reg_wr,
    output logic         reg_dst,
    output logic [1:0]   wb_sel,
    output logic [2:0]   alu_op,
    output logic         alu_a_sel,
    output logic [1:0]   alu_b_sel,
    output logic         pc_wr,
    output logic         pc_wr_cond,
    output logic [1:0]   pc_src,
    output logic         daddr_sel,
    output logic         flag_upd
);

    state_e             state_q, state_d, exec_state;
    logic [ALUOP_W-1:0] alu_q, exec_alu;
    ctl_t               ctl;

    mc_ctrl_decode u_dec (
        .opcode     (opcode),
        .zero_flag  (zero_flag),
        .carry_flag (carry_flag),
        .exec_state (exec_state),
        .exec_alu   (exec_alu)
    );

    always_comb begin
        case (state_q)
            S_FETCH:   state_d = S_DECODE;
            S_DECODE:  state_d = exec_state;
            S_EX_ALU:  state_d = S_WB_ALU;
            S_MEM_LDD: state_d = S_WB_LDD;
            S_MEM_LDR: state_d = S_WB_LDR;
            default:   state_d = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FETCH;
            alu_q   <= AL_ADD;
        end else begin
            state_q <= state_d;
            if (state_q == S_DECODE) alu_q <= exec_alu;
        end
    end

    mc_ctrl_outputs u_out (
        .state (state_q),
        .alu_q (alu_q),
        .ctl   (ctl)
    );

    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign reg_wr     = ctl.reg_wr;
    assign reg_dst    = ctl.reg_dst;
    assign wb_sel     = ctl.wb_sel;
    assign alu_op     = ctl.alu_op;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_src     = ctl.pc_src;
    assign daddr_sel  = ctl.daddr_sel;
    assign flag_upd   = ctl.flag_upd;

    // R1: one cycle after a reset edge the fetch strobes are showing
    assert_reset_to_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_wr && pc_wr && mem_rd));

    // R2: Fetch is always followed by Decode
    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |=> (state_q == S_DECODE));

    // R3: a flag-updating execute cycle is followed by a register write
    assert_exec_then_wb_R3: assert property (@(posedge clk) disable iff (rst)
        flag_upd |=> (reg_wr && wb_sel == WB_ALU));

    // R8: a store cycle hands back to Fetch
    assert_store_returns_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (ir_wr && !reg_wr));

    // R9: taken zero branch
    assert_bz_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DECODE && opcode == OP_BZ && zero_flag)
        |=> (pc_wr_cond && !pc_wr && pc_src == PS_TARGET));

    // R9: untaken carry branch
    assert_bc_untaken_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DECODE && opcode == OP_BC && !carry_flag) |=> ir_wr);

    // R12: read and write strobes exclusive
    assert_mem_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R12: flag update only in the cycle after Decode
    assert_flag_upd_after_decode_R12: assert property (@(posedge clk) disable iff (rst)
        flag_upd |-> $past(state_q == S_DECODE));

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] opcode;
    logic       zero_flag, carry_flag;
    logic       mem_rd, mem_wr, ir_wr, reg_wr, reg_dst;
    logic [1:0] wb_sel, alu_b_sel, pc_src;
    logic [2:0] alu_op;
    logic       alu_a_sel, pc_wr, pc_wr_cond, daddr_sel, flag_upd;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mc_ctrl_fsm u0 (
        .clk(clk), .rst(rst), .opcode(opcode),
        .zero_flag(zero_flag), .carry_flag(carry_flag),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .reg_dst(reg_dst), .wb_sel(wb_sel), .alu_op(alu_op),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .daddr_sel(daddr_sel),
        .flag_upd(flag_upd)
    );

    // {mem_rd,mem_wr,ir_wr,reg_wr,reg_dst,wb_sel,alu_op,alu_a_sel,alu_b_sel,
    //  pc_wr,pc_wr_cond,pc_src,daddr_sel,flag_upd}
    function automatic logic [18:0] mk(input bit mrd, mwr, irw, rgw, rdst,
                                       input logic [1:0] wb, input logic [2:0] aop,
                                       input bit asel, input logic [1:0] bsel,
                                       input bit pcw, pcc, input logic [1:0] psrc,
                                       input bit das, fu);
        return {mrd, mwr, irw, rgw, rdst, wb, aop, asel, bsel, pcw, pcc, psrc, das, fu};
    endfunction

    function automatic logic [18:0] idle();
        return mk(0,0,0,0,0,2'b00,3'b010,0,2'b00,0,0,2'b00,0,0);
    endfunction

    localparam logic [18:0] V_FETCH  = 19'({1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,3'b010,1'b0,2'b01,1'b1,1'b0,2'b00,1'b0,1'b0});
    localparam logic [18:0] V_DECODE = 19'({1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'b010,1'b0,2'b10,1'b0,1'b0,2'b00,1'b0,1'b0});

    function automatic logic [18:0] v_exalu(input logic [2:0] aop);
        return mk(0,0,0,0,0,2'b00,aop,1,2'b00,0,0,2'b00,0,1);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [18:0] exp);
        logic [18:0] got;
        got = {mem_rd, mem_wr, ir_wr, reg_wr, reg_dst, wb_sel, alu_op, alu_a_sel,
               alu_b_sel, pc_wr, pc_wr_cond, pc_src, daddr_sel, flag_upd};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // R3 R4: ALU path with opcode disturbed after Decode
    task automatic t_alu(input logic [3:0] opc, input logic [2:0] aop);
        opcode = opc;
        chk("R2 fetch before alu", V_FETCH);
        step(); chk("R2 decode alu", V_DECODE);
        zero_flag = 1'b1; carry_flag = 1'b1;
        step(); opcode = 4'd7; #1;
        chk("R4 alu execute code", v_exalu(aop));
        zero_flag = 1'b0; carry_flag = 1'b0;
        step(); chk("R3 alu writeback", mk(0,0,0,1,0,2'b00,3'b010,0,2'b00,0,0,2'b00,0,0));
        step(); chk("R3 alu back to fetch", V_FETCH);
    endtask

    // generic path of one or two post-decode cycles
    task automatic t_path(input logic [3:0] opc, input string tag, input int n,
                          input logic [18:0] a, input logic [18:0] b);
        opcode = opc;
        step(); chk({tag, " decode"}, V_DECODE);
        step(); chk({tag, " first"}, a);
        if (n == 2) begin
            step(); chk({tag, " second"}, b);
        end
        step(); chk({tag, " back to fetch"}, V_FETCH);
    endtask

    // R9: branch decision in Decode
    task automatic t_branch(input logic [3:0] opc, input bit z, input bit c,
                            input bit taken, input string tag);
        opcode = opc;
        step(); chk({tag, " decode"}, V_DECODE);
        zero_flag = z; carry_flag = c;
        step();
        zero_flag = ~z; carry_flag = ~c;
        if (taken) begin
            chk({tag, " taken"}, mk(0,0,0,0,0,2'b00,3'b010,0,2'b00,0,1,2'b01,0,0));
            step();
        end
        chk({tag, " fetch"}, V_FETCH);
        zero_flag = 1'b0; carry_flag = 1'b0;
    endtask

    // R1: reset in the middle of an ALU path
    task automatic t_mid_reset();
        opcode = 4'd2;
        step(); step();
        chk("R1 pre-reset execute", v_exalu(3'b110));
        rst = 1'b1;
        step(); chk("R1 reset mid-path fetch", V_FETCH);
        rst = 1'b0;
        opcode = 4'd7;
        step(); chk("R1 decode after reset", V_DECODE);
        step(); chk("R5 imm after reset", mk(0,0,0,1,1,2'b10,3'b010,0,2'b00,0,0,2'b00,0,0));
        step(); chk("R1 fetch after reset", V_FETCH);
    endtask

    initial begin
        rst = 1'b1; opcode = 4'd0; zero_flag = 1'b0; carry_flag = 1'b0;
        step(); step();
        chk("R1 reset state", V_FETCH);
        rst = 1'b0;
        chk("R1 fetch after release", V_FETCH);

        t_alu(4'd0, 3'b010);
        t_alu(4'd1, 3'b100);
        t_alu(4'd2, 3'b110);
        t_alu(4'd3, 3'b101);
        t_alu(4'd4, 3'b000);
        t_alu(4'd5, 3'b001);
        t_alu(4'd6, 3'b011);

        t_path(4'd7,  "R5 imm load", 1,
               mk(0,0,0,1,1,2'b10,3'b010,0,2'b00,0,0,2'b00,0,0), idle());
        t_path(4'd8,  "R6 direct load", 2,
               mk(1,0,0,0,0,2'b00,3'b010,0,2'b00,0,0,2'b00,0,0),
               mk(0,0,0,1,1,2'b01,3'b010,0,2'b00,0,0,2'b00,0,0));
        t_path(4'd9,  "R7 indirect load", 2,
               mk(1,0,0,0,0,2'b00,3'b010,0,2'b00,0,0,2'b00,1,0),
               mk(0,0,0,1,0,2'b01,3'b010,0,2'b00,0,0,2'b00,0,0));
        t_path(4'd10, "R8 store", 1,
               mk(0,1,0,0,0,2'b00,3'b010,0,2'b00,0,0,2'b00,0,0), idle());

        t_branch(4'd11, 1, 0, 1, "R9 bz zero set");
        t_branch(4'd11, 0, 0, 0, "R9 bz clear");
        t_branch(4'd11, 0, 1, 0, "R9 bz only carry");
        t_branch(4'd12, 0, 1, 1, "R9 bc carry set");
        t_branch(4'd12, 0, 0, 0, "R9 bc clear");
        t_branch(4'd12, 1, 0, 0, "R9 bc only zero");

        t_path(4'd13, "R10 direct jump", 1,
               mk(0,0,0,0,0,2'b00,3'b010,0,2'b00,1,0,2'b10,0,0), idle());
        t_path(4'd14, "R10 register jump", 1,
               mk(0,0,0,0,0,2'b00,3'b010,0,2'b00,1,0,2'b11,0,0), idle());

        // R11: undefined opcode returns from Decode to Fetch
        opcode = 4'd15;
        step(); chk("R11 decode undefined", V_DECODE);
        step(); chk("R11 back to fetch", V_FETCH);

        // R12: flag_upd low outside ALU execute (observed through a load path)
        t_path(4'd8, "R12 no flag update on load", 2,
               mk(1,0,0,0,0,2'b00,3'b010,0,2'b00,0,0,2'b00,0,0),
               mk(0,0,0,1,1,2'b01,3'b010,0,2'b00,0,0,2'b00,0,0));

        t_mid_reset();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule